// File: doc/BRIEF.md
# Microprogrammed Control Sequencer with Bus Master

This block is the control unit of a small microcoded processor. A micro-program counter addresses a control store held in a synchronous RAM. Each microword it reads out supplies a vector of datapath control signals and a sequencing action. The action can be a plain step, a branch on one selected external condition, a dispatch through an opcode look-up table, or a wait on a bus transfer. Because each opcode's entry point comes from an editable table, a different instruction set, or a reduced one, needs new table contents and no new logic.

Bus transfers are driven by microcode. A wait microword raises a single-beat master request (cycle, strobe, write enable) and holds the micro-program counter until the slave acknowledges. The datapath supplies the address and the write data through the block. Read data is captured on the acknowledge and returned to the datapath. The fetch routine at microaddress 0 reads an instruction byte, and a dispatch word that follows it jumps to that opcode's microroutine. An opcode with no valid table entry is sent to a fixed trap routine and flagged.

Top module: `useq_core`

## Requirements
- R1: While reset is high and in the first cycle after it falls, upc_o is 0, wb_cyc_o, wb_stb_o and illegal_o are 0 and rdata_o is 0; contents written into the control store and the opcode table during reset are kept.
- R2: A step microword (sequence code 0) makes upc_o equal its address plus one in the next cycle.
- R3: A dispatch microword (code 2) whose opcode_i has a valid table entry makes upc_o equal that entry's start address in the next cycle.
- R4: A dispatch on an opcode with no valid entry makes upc_o equal TRAP_ADDR (default 62) in the next cycle, and illegal_o is high for exactly that one cycle.
- R5: A table write takes effect for every dispatch after its clock edge: a new start address redirects the opcode, and a write with the valid bit 0 sends it to the trap routine, with the control store unchanged.
- R6: A branch microword (code 1) goes to its branch address when cond_i[select] XOR invert is 1, and otherwise to its own address plus one.
- R7: A wait microword (code 3) holds wb_cyc_o and wb_stb_o high, wb_we_o at the word's write bit and wb_adr_o/wb_dat_o at bus_addr_i/bus_wdata_i, and holds upc_o until wb_ack_i is sampled high. upc_o then advances by one on that edge, so the word stays for exactly one cycle more than the slave's wait states.
- R8: rdata_o loads wb_dat_i on an edge where a read (write bit 0) is acknowledged and holds its value otherwise, including through write transfers.
- R9: Microword layout (default sizes): [1:0] sequence code, [7:2] branch address, [9:8] condition select, [10] condition invert, [11] bus write, [19:12] control vector. ctrl_o shows the control vector of the word at upc_o during the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_we | input | 1 | Control store write enable |
| cs_waddr | input | UA | Control store write address |
| cs_wdata | input | WORD_W | Microword to write |
| tbl_we | input | 1 | Opcode table write enable |
| tbl_opcode | input | OPC_W | Opcode whose entry is written |
| tbl_start | input | UA | Microroutine start address for that opcode |
| tbl_valid | input | 1 | Entry valid bit (0 removes the opcode) |
| opcode_i | input | OPC_W | Opcode used by dispatch microwords |
| cond_i | input | COND_N | External branch conditions |
| ctrl_o | output | CTRL_W | Datapath control vector of the current microword |
| upc_o | output | UA | Current micro-program counter |
| illegal_o | output | 1 | One-cycle flag: dispatch hit an invalid opcode |
| bus_addr_i | input | ADR_W | Transfer address from the datapath |
| bus_wdata_i | input | DAT_W | Write data from the datapath |
| rdata_o | output | DAT_W | Last read data captured from the bus |
| wb_cyc_o | output | 1 | Bus cycle request |
| wb_stb_o | output | 1 | Bus strobe |
| wb_we_o | output | 1 | Bus write enable |
| wb_adr_o | output | ADR_W | Bus address |
| wb_dat_o | output | DAT_W | Bus write data |
| wb_dat_i | input | DAT_W | Bus read data |
| wb_ack_i | input | 1 | Bus acknowledge |

## Verification
Every sequencing decision is visible one clock after the cycle that makes it. The new upc_o, its ctrl_o and any illegal_o pulse all appear together in the cycle after the step, branch or dispatch word. A wait word stays for its slave's wait-state count plus one cycle, and rdata_o changes on the edge of a read acknowledge. The bench drives every input on the falling edge and samples on the falling edge. It compares upc_o only when it changes, against a queue of expected addresses, and checks the control vector, the trap flag and the captured data there. The bus slave compares each acknowledged transfer with an expected-transfer queue and counts the cycles spent in each wait word.

// File: rtl/useq_pkg.sv
package useq_pkg;
  // Sequencing action carried in the low bits of every microword.
  typedef enum logic [1:0] {
    SEQ_NEXT     = 2'd0,
    SEQ_BRANCH   = 2'd1,
    SEQ_DISPATCH = 2'd2,
    SEQ_WAIT     = 2'd3
  } seq_e;
endpackage

// File: rtl/useq_ctrl_store.sv
// Control store: single write port, registered read port (block RAM style).
module useq_ctrl_store #(
  parameter int AW = 6,
  parameter int DW = 20,
  localparam int DEPTH = 2 ** AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/useq_dispatch_table.sv
// Opcode translation table: start address plus valid bit per opcode.
module useq_dispatch_table #(
  parameter int OPC_W = 8,
  parameter int UA    = 6,
  localparam int ENTRIES = 2 ** OPC_W
) (
  input  logic             clk,
  input  logic             we,
  input  logic [OPC_W-1:0] wopc,
  input  logic [UA-1:0]    wstart,
  input  logic             wvalid,
  input  logic [OPC_W-1:0] ropc,
  output logic [UA-1:0]    start,
  output logic             valid
);
  logic [UA:0] tbl [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) tbl[wopc] <= {wvalid, wstart};
  end

  assign {valid, start} = tbl[ropc];
endmodule

// File: rtl/useq_next_addr.sv
// Combinational next-microaddress selection; feeds the RAM address port.
module useq_next_addr
  import useq_pkg::*;
#(
  parameter int UA        = 6,
  parameter int COND_N    = 4,
  parameter int TRAP_ADDR = 62,
  localparam int CSEL_W = (COND_N > 1) ? $clog2(COND_N) : 1,
  localparam int CPAD_N = 2 ** CSEL_W
) (
  input  logic              live,
  input  logic [UA-1:0]     upc,
  input  seq_e              seq,
  input  logic [UA-1:0]     baddr,
  input  logic [CSEL_W-1:0] csel,
  input  logic              cinv,
  input  logic [COND_N-1:0] cond,
  input  logic              ack,
  input  logic [UA-1:0]     tbl_start,
  input  logic              tbl_valid,
  output logic [UA-1:0]     nxt,
  output logic              bad_op
);
  localparam logic [UA-1:0] ONE  = UA'(1);
  localparam logic [UA-1:0] TRAP = UA'(TRAP_ADDR);

  logic [CPAD_N-1:0] cpad;
  logic [UA-1:0]     inc;
  logic              take;

  always_comb begin
    cpad = '0;
    cpad[COND_N-1:0] = cond;
  end

  assign inc  = upc + ONE;
  assign take = cpad[csel] ^ cinv;

  always_comb begin
    nxt = inc;
    if (!live) begin
      nxt = upc;
    end else begin
      unique case (seq)
        SEQ_NEXT:     nxt = inc;
        SEQ_BRANCH:   nxt = take ? baddr : inc;
        SEQ_DISPATCH: nxt = tbl_valid ? tbl_start : TRAP;
        SEQ_WAIT:     nxt = ack ? inc : upc;
        default:      nxt = inc;
      endcase
    end
  end

  assign bad_op = live && (seq == SEQ_DISPATCH) && !tbl_valid;
endmodule

// File: rtl/useq_bus_master.sv
// Single-beat bus master driven by the current microword.
module useq_bus_master #(
  parameter int ADR_W = 16,
  parameter int DAT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             wr,
  input  logic [ADR_W-1:0] addr,
  input  logic [DAT_W-1:0] wdata,
  input  logic             ack,
  input  logic [DAT_W-1:0] dat_i,
  output logic             cyc,
  output logic             stb,
  output logic             we,
  output logic [ADR_W-1:0] adr,
  output logic [DAT_W-1:0] dat_o,
  output logic [DAT_W-1:0] rdata
);
  assign cyc   = req;
  assign stb   = req;
  assign we    = req && wr;
  assign adr   = addr;
  assign dat_o = wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (req && ack && !wr) begin
      rdata <= dat_i;
    end
  end
endmodule

// File: rtl/useq_core.sv
// Microprogrammed sequencer top: uPC register, control store, opcode
// table, next-address logic and bus master.
module useq_core
  import useq_pkg::*;
#(
  parameter int OPC_W     = 8,
  parameter int UA        = 6,
  parameter int CTRL_W    = 8,
  parameter int COND_N    = 4,
  parameter int ADR_W     = 16,
  parameter int DAT_W     = 8,
  parameter int TRAP_ADDR = 62,
  localparam int CSEL_W = (COND_N > 1) ? $clog2(COND_N) : 1,
  localparam int WORD_W = 2 + UA + CSEL_W + 2 + CTRL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_we,
  input  logic [UA-1:0]     cs_waddr,
  input  logic [WORD_W-1:0] cs_wdata,
  input  logic              tbl_we,
  input  logic [OPC_W-1:0]  tbl_opcode,
  input  logic [UA-1:0]     tbl_start,
  input  logic              tbl_valid,
  input  logic [OPC_W-1:0]  opcode_i,
  input  logic [COND_N-1:0] cond_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [UA-1:0]     upc_o,
  output logic              illegal_o,
  input  logic [ADR_W-1:0]  bus_addr_i,
  input  logic [DAT_W-1:0]  bus_wdata_i,
  output logic [DAT_W-1:0]  rdata_o,
  output logic              wb_cyc_o,
  output logic              wb_stb_o,
  output logic              wb_we_o,
  output logic [ADR_W-1:0]  wb_adr_o,
  output logic [DAT_W-1:0]  wb_dat_o,
  input  logic [DAT_W-1:0]  wb_dat_i,
  input  logic              wb_ack_i
);
  // Microword field positions.
  localparam int BA_LO = 2;
  localparam int CS_LO = BA_LO + UA;
  localparam int INV_B = CS_LO + CSEL_W;
  localparam int WE_B  = INV_B + 1;
  localparam int CT_LO = WE_B + 1;

  logic              live_q;
  logic              illegal_q;
  logic [UA-1:0]     upc_q;
  logic [UA-1:0]     nxt;
  logic [UA-1:0]     raddr;
  logic [WORD_W-1:0] word;
  logic              bad_op;
  logic [UA-1:0]     t_start;
  logic              t_valid;
  seq_e              seq;
  logic              bus_req;

  assign seq     = seq_e'(word[1:0]);
  assign bus_req = live_q && (seq == SEQ_WAIT);
  // Reset parks the RAM read on the fetch routine.
  assign raddr   = rst ? '0 : nxt;

  useq_ctrl_store #(.AW(UA), .DW(WORD_W)) u_store (
    .clk   (clk),
    .we    (cs_we),
    .waddr (cs_waddr),
    .wdata (cs_wdata),
    .raddr (raddr),
    .rdata (word)
  );

  useq_dispatch_table #(.OPC_W(OPC_W), .UA(UA)) u_table (
    .clk    (clk),
    .we     (tbl_we),
    .wopc   (tbl_opcode),
    .wstart (tbl_start),
    .wvalid (tbl_valid),
    .ropc   (opcode_i),
    .start  (t_start),
    .valid  (t_valid)
  );

  useq_next_addr #(.UA(UA), .COND_N(COND_N), .TRAP_ADDR(TRAP_ADDR)) u_next (
    .live      (live_q),
    .upc       (upc_q),
    .seq       (seq),
    .baddr     (word[CS_LO-1:BA_LO]),
    .csel      (word[INV_B-1:CS_LO]),
    .cinv      (word[INV_B]),
    .cond      (cond_i),
    .ack       (wb_ack_i),
    .tbl_start (t_start),
    .tbl_valid (t_valid),
    .nxt       (nxt),
    .bad_op    (bad_op)
  );

  useq_bus_master #(.ADR_W(ADR_W), .DAT_W(DAT_W)) u_bus (
    .clk   (clk),
    .rst   (rst),
    .req   (bus_req),
    .wr    (word[WE_B]),
    .addr  (bus_addr_i),
    .wdata (bus_wdata_i),
    .ack   (wb_ack_i),
    .dat_i (wb_dat_i),
    .cyc   (wb_cyc_o),
    .stb   (wb_stb_o),
    .we    (wb_we_o),
    .adr   (wb_adr_o),
    .dat_o (wb_dat_o),
    .rdata (rdata_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q    <= 1'b0;
      upc_q     <= '0;
      illegal_q <= 1'b0;
    end else begin
      live_q    <= 1'b1;
      upc_q     <= nxt;
      illegal_q <= bad_op;
    end
  end

  assign upc_o     = upc_q;
  assign illegal_o = illegal_q;
  assign ctrl_o    = word[WORD_W-1:CT_LO];
endmodule

// File: rtl/useq_core_chk.sv
// Temporal checks on the sequencer ports.
module useq_core_chk #(
  parameter int UA        = 6,
  parameter int DAT_W     = 8,
  parameter int TRAP_ADDR = 62
) (
  input logic             clk,
  input logic             rst,
  input logic             cyc,
  input logic             ack,
  input logic             we,
  input logic [UA-1:0]    upc,
  input logic             illegal,
  input logic [DAT_W-1:0] rdata
);
  // R1: quiet first cycle after reset
  a_r1_quiet_start: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!cyc && (upc == '0) && !illegal));

  // R7: no acknowledge keeps the microaddress
  a_r7_hold_wait: assert property (@(posedge clk) disable iff (rst)
    (cyc && !ack) |=> $stable(upc));

  // R7: acknowledge releases the wait word
  a_r7_leave_on_ack: assert property (@(posedge clk) disable iff (rst)
    (cyc && ack) |=> (upc != $past(upc)));

  // R8: read data only moves on a read acknowledge
  a_r8_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !(cyc && ack && !we) |=> $stable(rdata));

  // R4: trap flag coincides with the trap routine entry
  a_r4_trap_flag: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (upc == UA'(TRAP_ADDR)));
endmodule

bind useq_core useq_core_chk #(.UA(UA), .DAT_W(DAT_W), .TRAP_ADDR(TRAP_ADDR)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .cyc     (wb_cyc_o),
  .ack     (wb_ack_i),
  .we      (wb_we_o),
  .upc     (upc_o),
  .illegal (illegal_o),
  .rdata   (rdata_o)
);

// File: tb/useq_core_tb_top.sv
module useq_core_tb_top;
  localparam int WW = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_we = 1'b0;
  logic [5:0]  cs_waddr = '0;
  logic [WW-1:0] cs_wdata = '0;
  logic        tbl_we = 1'b0;
  logic [7:0]  tbl_opcode = '0;
  logic [5:0]  tbl_start = '0;
  logic        tbl_valid = 1'b0;
  logic [7:0]  opcode_i;
  logic [3:0]  cond_i = '0;
  logic [7:0]  ctrl_o;
  logic [5:0]  upc_o;
  logic        illegal_o;
  logic [15:0] bus_addr_i;
  logic [7:0]  bus_wdata_i;
  logic [7:0]  rdata_o;
  logic        wb_cyc_o, wb_stb_o, wb_we_o;
  logic [15:0] wb_adr_o;
  logic [7:0]  wb_dat_o;
  logic [7:0]  wb_dat_i = '0;
  logic        wb_ack_i = 1'b0;

  always #10 clk = ~clk;

  // Demo datapath: fetched byte is the opcode, address/data follow ctrl.
  assign opcode_i    = rdata_o;
  assign bus_addr_i  = {8'h00, ctrl_o};
  assign bus_wdata_i = ctrl_o ^ 8'hA5;

  useq_core dut_i (
    .clk(clk), .rst(rst), .cs_we(cs_we), .cs_waddr(cs_waddr), .cs_wdata(cs_wdata),
    .tbl_we(tbl_we), .tbl_opcode(tbl_opcode), .tbl_start(tbl_start), .tbl_valid(tbl_valid),
    .opcode_i(opcode_i), .cond_i(cond_i), .ctrl_o(ctrl_o), .upc_o(upc_o),
    .illegal_o(illegal_o), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .rdata_o(rdata_o), .wb_cyc_o(wb_cyc_o), .wb_stb_o(wb_stb_o), .wb_we_o(wb_we_o),
    .wb_adr_o(wb_adr_o), .wb_dat_o(wb_dat_o), .wb_dat_i(wb_dat_i), .wb_ack_i(wb_ack_i)
  );

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;
  int lat = 0;
  logic [7:0] exp_d = '0;
  int ill_seen = 0;

  logic [5:0]  exp_upc [$];
  logic [24:0] exp_bus [$];   // {we, adr, wdata}
  logic [7:0]  rd_q [$];

  task automatic check(input bit ok, input string what, input int act, input int expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, expv);
    end
  endtask

  // Microword builder, layout of R9.
  function automatic logic [WW-1:0] mw(input logic [7:0] c, input logic w, input logic inv,
                                       input logic [1:0] cs, input logic [5:0] ba,
                                       input logic [1:0] sq);
    return {c, w, inv, cs, ba, sq};
  endfunction

  // Demo image. cond_i[3] is tied 0, so an inverted test of it always jumps.
  function automatic logic [WW-1:0] img(input int a);
    case (a)
      0:  return mw(8'h01, 0, 0, 2'd0, 6'd0,  2'd3);
      1:  return mw(8'h02, 0, 0, 2'd0, 6'd0,  2'd2);
      8:  return mw(8'h10, 0, 0, 2'd0, 6'd0,  2'd0);
      9:  return mw(8'h11, 1, 0, 2'd0, 6'd0,  2'd3);
      10: return mw(8'h12, 0, 1, 2'd3, 6'd0,  2'd1);
      16: return mw(8'h20, 0, 0, 2'd0, 6'd0,  2'd3);
      17: return mw(8'h21, 0, 0, 2'd1, 6'd20, 2'd1);
      18: return mw(8'h22, 0, 0, 2'd0, 6'd0,  2'd0);
      19: return mw(8'h23, 0, 1, 2'd3, 6'd0,  2'd1);
      20: return mw(8'h24, 0, 0, 2'd0, 6'd0,  2'd0);
      21: return mw(8'h25, 0, 1, 2'd3, 6'd0,  2'd1);
      62: return mw(8'h3E, 0, 0, 2'd0, 6'd0,  2'd0);
      63: return mw(8'h3F, 0, 1, 2'd3, 6'd0,  2'd1);
      default: return mw(8'hFF, 0, 1, 2'd3, 6'd0, 2'd1);
    endcase
  endfunction

  task automatic tbl_write(input logic [7:0] op, input logic [5:0] st, input logic v);
    @(negedge clk);
    tbl_we = 1'b1; tbl_opcode = op; tbl_start = st; tbl_valid = v;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  // Driver. kind 0: path via 8, 1: branch taken at 17, 2: not taken, 3: trap.
  task automatic exec(input logic [7:0] op, input int kind, input logic c1,
                      input int l, input logic [7:0] d);
    int ill0;
    cond_i = {2'b00, c1, 1'b0};
    lat = l;
    exp_d = d;
    ill0 = ill_seen;
    exp_upc.push_back(6'd1);
    exp_bus.push_back({1'b0, 16'h0001, 8'h00});
    case (kind)
      0: begin
        exp_upc.push_back(6'd8); exp_upc.push_back(6'd9); exp_upc.push_back(6'd10);
        exp_bus.push_back({1'b1, 16'h0011, 8'h11 ^ 8'hA5});
      end
      1: begin
        exp_upc.push_back(6'd16); exp_upc.push_back(6'd17);
        exp_upc.push_back(6'd20); exp_upc.push_back(6'd21);
        exp_bus.push_back({1'b0, 16'h0020, 8'h00});
      end
      2: begin
        exp_upc.push_back(6'd16); exp_upc.push_back(6'd17);
        exp_upc.push_back(6'd18); exp_upc.push_back(6'd19);
        exp_bus.push_back({1'b0, 16'h0020, 8'h00});
      end
      default: begin
        exp_upc.push_back(6'd62); exp_upc.push_back(6'd63);
      end
    endcase
    exp_upc.push_back(6'd0);
    rd_q.push_back(op);
    if (kind == 1 || kind == 2) rd_q.push_back(d);
    while (exp_upc.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(exp_bus.size() == 0, "R7 all transfers seen", exp_bus.size(), 0);
    if (kind == 0)
      check(rdata_o == op, "R8 write leaves rdata", rdata_o, op);
    else if (kind != 3)
      check(rdata_o == d, "R8 read data kept", rdata_o, d);
    check(ill_seen == ill0 + ((kind == 3) ? 1 : 0), "R4 illegal pulse count",
          ill_seen - ill0, (kind == 3) ? 1 : 0);
  endtask

  // Bus slave and transfer monitor.
  int cnt = 0;
  always @(negedge clk) begin
    if (rst || wb_ack_i) begin
      wb_ack_i = 1'b0;
      cnt = 0;
    end else if (wb_cyc_o && wb_stb_o && (wb_we_o || rd_q.size() > 0)) begin
      if (cnt >= lat) begin
        logic [24:0] e;
        wb_ack_i = 1'b1;
        if (exp_bus.size() == 0) begin
          check(1'b0, "R7 unexpected transfer", wb_adr_o, 0);
        end else begin
          e = exp_bus.pop_front();
          check(wb_we_o == e[24], "R7 write enable", wb_we_o, e[24]);
          check(wb_adr_o == e[23:8], "R7 address", wb_adr_o, e[23:8]);
          if (e[24]) check(wb_dat_o == e[7:0], "R7 write data", wb_dat_o, e[7:0]);
        end
        if (!wb_we_o) wb_dat_i = rd_q.pop_front();
      end else begin
        cnt++;
      end
    end
  end

  // Microaddress monitor: scoreboard of visited addresses.
  logic [5:0] prev = '0;
  int dwell = 1;
  int post = 0;
  always @(negedge clk) begin
    if (rst) begin
      prev = '0; dwell = 1; post = 0;
    end else begin
      post++;
      if (illegal_o) ill_seen++;
      if (post > 1)
        check(wb_cyc_o == (upc_o == 0 || upc_o == 9 || upc_o == 16), "R7 cyc matches wait word",
              wb_cyc_o, (upc_o == 0 || upc_o == 9 || upc_o == 16));
      if (upc_o != prev) begin
        logic [5:0] e;
        logic [WW-1:0] w;
        string tag;
        if (prev == 1) tag = (upc_o == 62) ? "R4 trap dispatch" : "R3 dispatch target";
        else if (prev == 17) tag = "R6 branch target";
        else tag = "R2 sequence";
        if (prev == 9 || prev == 16)
          check(dwell == lat + 1, "R7 wait dwell", dwell, lat + 1);
        if (exp_upc.size() == 0) begin
          check(1'b0, tag, upc_o, prev);
        end else begin
          e = exp_upc.pop_front();
          check(upc_o == e, tag, upc_o, e);
        end
        w = img(int'(upc_o));
        check(ctrl_o == w[19:12], "R9 ctrl vector", ctrl_o, w[19:12]);
        if (upc_o == 62) check(illegal_o, "R4 flag with trap entry", illegal_o, 1);
        if (upc_o == 17) check(rdata_o == exp_d, "R8 read capture", rdata_o, exp_d);
        prev = upc_o;
        dwell = 1;
      end else begin
        dwell++;
      end
    end
  end

  initial begin
    // Load control store and opcode table during reset.
    for (int a = 0; a < 64; a++) begin
      @(negedge clk);
      cs_we = 1'b1; cs_waddr = 6'(a); cs_wdata = img(a);
    end
    @(negedge clk);
    cs_we = 1'b0;
    for (int o = 0; o < 256; o++) begin
      @(negedge clk);
      tbl_we = 1'b1; tbl_opcode = 8'(o); tbl_start = '0; tbl_valid = 1'b0;
    end
    @(negedge clk);
    tbl_we = 1'b0;
    tbl_write(8'h10, 6'd8, 1'b1);
    tbl_write(8'h20, 6'd16, 1'b1);
    tbl_write(8'h30, 6'd8, 1'b1);
    repeat (2) @(negedge clk);
    check(upc_o == 0, "R1 upc in reset", upc_o, 0);
    check(!wb_cyc_o && !wb_stb_o, "R1 bus idle in reset", wb_cyc_o, 0);
    check(!illegal_o, "R1 illegal in reset", illegal_o, 0);
    check(rdata_o == 0, "R1 rdata in reset", rdata_o, 0);
    check(ctrl_o == 8'h01, "R1 fetch word ready", ctrl_o, 8'h01);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(!wb_cyc_o && upc_o == 0, "R1 first cycle quiet", wb_cyc_o, 0);

    exec(8'h10, 0, 1'b0, 0, 8'h00);
    exec(8'h20, 1, 1'b1, 3, 8'h5A);
    exec(8'h20, 2, 1'b0, 1, 8'hC3);
    exec(8'h55, 3, 1'b0, 2, 8'h00);
    exec(8'h30, 0, 1'b0, 2, 8'h00);
    tbl_write(8'h30, 6'd0, 1'b0);            // R5 delete entry
    exec(8'h30, 3, 1'b0, 0, 8'h00);
    tbl_write(8'h20, 6'd8, 1'b1);            // R5 redirect entry
    exec(8'h20, 0, 1'b1, 4, 8'h00);
    exec(8'h10, 0, 1'b0, 5, 8'h00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      vectors++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule